// File: doc/BRIEF.md
# Input Capture Channel with Two-Stage Holding Queue

This block is one input-capture channel. When a qualified edge strobe arrives, it takes a snapshot of a free-running timer. The snapshot goes into a capture stage. Behind the capture stage sits a holding stage, so the channel can keep two snapshots in queue order: the newest in capture and the one before it in holding. Software empties each stage with its own read strobe. A read strobe is a single-cycle pulse, and the value in the stage is sampled in that same cycle.

A per-channel no-overwrite control sets the policy when the queue is full.
- With the control cleared, each new snapshot pushes the older capture value into holding and overwrites whatever holding had.
- With the control set, a stored value is never displaced. A snapshot that finds both stages occupied is discarded, and a sticky lost flag is raised.

A second, independent path copies a pulse-accumulator count into its own holding register when software reads the capture holding stage. This copy happens only while queue mode is selected.

The occupancy of the two stages is held in a four-state machine:
- `ST_EMPTY`: nothing stored.
- `ST_CAP`: capture stage full only.
- `ST_HOLD`: holding stage full only.
- `ST_BOTH`: both stages full.

Each cycle, the reads are applied first. The resulting "effective" state then decides the transition:
- load: the snapshot enters an empty capture stage.
- shift-load: capture moves to holding, and the snapshot enters capture.
- overwrite-shift: the same as shift-load with no-overwrite cleared, discarding the old holding value.
- drop: the snapshot is discarded with no-overwrite set.
- drain: reads alone free stages.

Top module: `ic_queue_chan`

## Requirements
- R1: After reset, both full flags are 0, the capture and holding data are 0, the lost flag is 0 and the accumulator holding value is 0.
- R2: An edge strobe that finds the capture stage empty (after same-cycle reads) stores the timer value in capture one cycle later and sets the capture full flag. The holding stage is unchanged.
- R3: With no-overwrite = 0 and both stages full, an edge strobe moves the capture value into holding, overwriting it, and stores the timer value in capture.
- R4: With the capture stage full and the holding stage empty, an edge strobe moves the capture value into holding, stores the timer value in capture, and sets both full flags. This holds for either setting of no-overwrite.
- R5: With no-overwrite = 1 and both stages full (no same-cycle read), an edge strobe changes neither stage and sets the lost flag.
- R6: A capture read strobe clears the capture full flag, and a holding read strobe clears the holding full flag, on the next cycle, unless a same-cycle capture refills that stage.
- R7: When a read strobe and an edge strobe share a cycle, the data output holds the pre-capture value during that cycle. The read frees its stage before the capture decision is made.
- R8: With queue mode = 1, a holding read strobe copies the accumulator input into the accumulator holding register one cycle later. With queue mode = 0, a holding read leaves that register unchanged.
- R9: With no-overwrite = 1, the capture stage empty and the holding stage full, an edge strobe writes only the capture stage, and holding keeps its value.
- R10: The lost flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_vld | input | 1 | Qualified edge strobe, one cycle |
| timer_val | input | TMR_W | Free-running timer value |
| pacc_val | input | ACC_W | Pulse-accumulator count |
| no_ovw | input | 1 | 1 = stored values are never displaced |
| queue_mode | input | 1 | 1 = holding read copies accumulator count |
| rd_cap | input | 1 | Software read strobe, capture stage |
| rd_hold | input | 1 | Software read strobe, holding stage |
| cap_data | output | TMR_W | Capture stage value |
| hold_data | output | TMR_W | Holding stage value |
| pacc_hold | output | ACC_W | Accumulator holding value |
| cap_full | output | 1 | Capture stage occupied |
| hold_full | output | 1 | Holding stage occupied |
| cap_lost | output | 1 | Sticky: a snapshot was discarded |

## Verification
Captures are driven from each of the four occupancy states with each setting of no-overwrite. This separates the overwrite-shift path from the drop path: only these two differ when both stages are full. It also separates the shift-load path from the plain load when only holding is occupied.

Reads are placed alone, together, and on the same cycle as a capture. These cases show whether a read frees its stage before the capture decision is made, and whether the output still shows the old value during that cycle.

Holding reads are repeated with queue mode set and then cleared, to tell a real accumulator copy from a stale one.

// File: rtl/ic_queue_pkg.sv
package ic_queue_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_CAP   = 2'b01,
        ST_HOLD  = 2'b10,
        ST_BOTH  = 2'b11
    } occ_state_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'b00,
        ACT_LOAD  = 2'b01,
        ACT_SHIFT = 2'b10,
        ACT_DROP  = 2'b11
    } cap_act_e;
endpackage

// File: rtl/ic_queue_ctrl.sv
module ic_queue_ctrl
    import ic_queue_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_vld,
    input  logic no_ovw,
    input  logic rd_cap,
    input  logic rd_hold,
    output logic load_cap,
    output logic shift_hold,
    output logic cap_full,
    output logic hold_full,
    output logic cap_lost
);
    occ_state_e state_q, state_d;
    cap_act_e   act;
    logic       cf_now, hf_now, cf_eff, hf_eff;
    logic       lost_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        cf_now = 1'b0;
        hf_now = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin cf_now = 1'b0; hf_now = 1'b0; end
            ST_CAP:   begin cf_now = 1'b1; hf_now = 1'b0; end
            ST_HOLD:  begin cf_now = 1'b0; hf_now = 1'b1; end
            ST_BOTH:  begin cf_now = 1'b1; hf_now = 1'b1; end
            default:  begin cf_now = 1'b0; hf_now = 1'b0; end
        endcase
        cf_eff = cf_now & ~rd_cap;
        hf_eff = hf_now & ~rd_hold;
    end

    always_comb begin
        act     = ACT_NONE;
        state_d = occ_state_e'({hf_eff, cf_eff});
        if (edge_vld) begin
            unique case (occ_state_e'({hf_eff, cf_eff}))
                ST_EMPTY: begin act = ACT_LOAD;  state_d = ST_CAP;  end
                ST_HOLD:  begin act = ACT_LOAD;  state_d = ST_BOTH; end
                ST_CAP:   begin act = ACT_SHIFT; state_d = ST_BOTH; end
                ST_BOTH: begin
                    if (no_ovw) begin act = ACT_DROP;  state_d = ST_BOTH; end
                    else        begin act = ACT_SHIFT; state_d = ST_BOTH; end
                end
                default:  begin act = ACT_NONE;  state_d = ST_EMPTY; end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              lost_q <= 1'b0;
        else if (act == ACT_DROP) lost_q <= 1'b1;
    end

    always_comb begin
        load_cap   = (act == ACT_LOAD) || (act == ACT_SHIFT);
        shift_hold = (act == ACT_SHIFT);
        cap_full   = cf_now;
        hold_full  = hf_now;
        cap_lost   = lost_q;
    end

    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lost_q |=> lost_q); // R10
    AST_DROP_SETS_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_vld && no_ovw && cf_now && hf_now && !rd_cap && !rd_hold) |=> (lost_q && state_q == ST_BOTH)); // R5
    AST_RD_CAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cap && !edge_vld) |=> !cap_full); // R6
endmodule

// File: rtl/ic_queue_regs.sv
module ic_queue_regs #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_cap,
    input  logic             shift_hold,
    input  logic [TMR_W-1:0] timer_val,
    output logic [TMR_W-1:0] cap_data,
    output logic [TMR_W-1:0] hold_data
);
    logic [TMR_W-1:0] cap_q, hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= '0;
            hold_q <= '0;
        end else begin
            if (shift_hold) hold_q <= cap_q;
            if (load_cap)   cap_q  <= timer_val;
        end
    end

    assign cap_data  = cap_q;
    assign hold_data = hold_q;

    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        shift_hold |=> hold_q == $past(cap_q)); // R3
    AST_IDLE_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_hold |=> $stable(hold_q)); // R9
endmodule

// File: rtl/ic_pacc_latch.sv
module ic_pacc_latch #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             queue_mode,
    input  logic             rd_hold,
    input  logic [ACC_W-1:0] pacc_val,
    output logic [ACC_W-1:0] pacc_hold
);
    logic [ACC_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                    ph_q <= '0;
        else if (queue_mode && rd_hold) ph_q <= pacc_val;
    end

    assign pacc_hold = ph_q;

    AST_PACC_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_mode && rd_hold) |=> ph_q == $past(pacc_val)); // R8
    AST_PACC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(queue_mode && rd_hold) |=> $stable(ph_q)); // R8
endmodule

// File: rtl/ic_queue_chan.sv
module ic_queue_chan #(
    parameter int TMR_W = 16,
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_vld,
    input  logic [TMR_W-1:0] timer_val,
    input  logic [ACC_W-1:0] pacc_val,
    input  logic             no_ovw,
    input  logic             queue_mode,
    input  logic             rd_cap,
    input  logic             rd_hold,
    output logic [TMR_W-1:0] cap_data,
    output logic [TMR_W-1:0] hold_data,
    output logic [ACC_W-1:0] pacc_hold,
    output logic             cap_full,
    output logic             hold_full,
    output logic             cap_lost
);
    logic load_cap, shift_hold;

    ic_queue_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_vld   (edge_vld),
        .no_ovw     (no_ovw),
        .rd_cap     (rd_cap),
        .rd_hold    (rd_hold),
        .load_cap   (load_cap),
        .shift_hold (shift_hold),
        .cap_full   (cap_full),
        .hold_full  (hold_full),
        .cap_lost   (cap_lost)
    );

    ic_queue_regs #(.TMR_W(TMR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_cap   (load_cap),
        .shift_hold (shift_hold),
        .timer_val  (timer_val),
        .cap_data   (cap_data),
        .hold_data  (hold_data)
    );

    ic_pacc_latch #(.ACC_W(ACC_W)) u_pacc (
        .clk        (clk),
        .rst_n      (rst_n),
        .queue_mode (queue_mode),
        .rd_hold    (rd_hold),
        .pacc_val   (pacc_val),
        .pacc_hold  (pacc_hold)
    );

    AST_CAPTURE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_vld && !(no_ovw && cap_full && hold_full && !rd_cap && !rd_hold))
        |=> (cap_data == $past(timer_val) && cap_full)); // R2
    AST_DROP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_vld && no_ovw && cap_full && hold_full && !rd_cap && !rd_hold)
        |=> ($stable(cap_data) && $stable(hold_data))); // R5
    AST_PARTIAL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_vld && cap_full && !rd_cap && !(hold_full && !rd_hold))
        |=> (hold_data == $past(cap_data) && hold_full)); // R4
    AST_RD_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold && !(edge_vld && cap_full && !rd_cap)) |=> !hold_full); // R6
endmodule

// File: tb/ic_queue_chan_bench.sv
module ic_queue_chan_bench;
    localparam int TW = 16;
    localparam int AW = 16;
    localparam int NV = 13;

    typedef struct packed {
        logic          ev;
        logic          nov;
        logic          rc;
        logic          rh;
        logic          qm;
        logic [TW-1:0] tmr;
        logic [AW-1:0] pac;
        logic [TW-1:0] ecap;
        logic [TW-1:0] ehold;
        logic          ecf;
        logic          ehf;
        logic          elost;
        logic [AW-1:0] epacc;
    } vec_t;

    // ev nov rc rh qm  tmr  pac  | ecap  ehold cf hf lost epacc
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0011,16'h0000,16'h0011,16'h0000,1'b1,1'b0,1'b0,16'h0000}, // R2
        '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0022,16'h0000,16'h0022,16'h0011,1'b1,1'b1,1'b0,16'h0000}, // R4
        '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0033,16'h0000,16'h0033,16'h0022,1'b1,1'b1,1'b0,16'h0000}, // R3
        '{1'b1,1'b1,1'b0,1'b0,1'b0,16'h0044,16'h0000,16'h0033,16'h0022,1'b1,1'b1,1'b1,16'h0000}, // R5
        '{1'b0,1'b1,1'b0,1'b1,1'b1,16'h0000,16'h5A5A,16'h0033,16'h0022,1'b1,1'b0,1'b1,16'h5A5A}, // R6 R8
        '{1'b1,1'b1,1'b0,1'b0,1'b0,16'h0055,16'h0000,16'h0055,16'h0033,1'b1,1'b1,1'b1,16'h5A5A}, // R4
        '{1'b0,1'b1,1'b1,1'b0,1'b0,16'h0000,16'h0000,16'h0055,16'h0033,1'b0,1'b1,1'b1,16'h5A5A}, // R6
        '{1'b1,1'b1,1'b0,1'b0,1'b0,16'h0066,16'h0000,16'h0066,16'h0033,1'b1,1'b1,1'b1,16'h5A5A}, // R9
        '{1'b1,1'b1,1'b1,1'b0,1'b0,16'h0077,16'h0000,16'h0077,16'h0033,1'b1,1'b1,1'b1,16'h5A5A}, // R7
        '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,16'h1234,16'h0077,16'h0033,1'b1,1'b0,1'b1,16'h5A5A}, // R8
        '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h0000,16'h0000,16'h0077,16'h0033,1'b0,1'b0,1'b1,16'h5A5A}, // R10
        '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0088,16'h0000,16'h0088,16'h0033,1'b1,1'b0,1'b1,16'h5A5A}, // R2
        '{1'b1,1'b0,1'b1,1'b0,1'b0,16'h0099,16'h0000,16'h0099,16'h0033,1'b1,1'b0,1'b1,16'h5A5A}  // R7
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          edge_vld = 1'b0;
    logic [TW-1:0] timer_val = '0;
    logic [AW-1:0] pacc_val = '0;
    logic          no_ovw = 1'b0;
    logic          queue_mode = 1'b0;
    logic          rd_cap = 1'b0;
    logic          rd_hold = 1'b0;
    logic [TW-1:0] cap_data, hold_data;
    logic [AW-1:0] pacc_hold;
    logic          cap_full, hold_full, cap_lost;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ic_queue_chan #(.TMR_W(TW), .ACC_W(AW)) u_ic_queue_chan (
        .clk(clk), .rst_n(rst_n), .edge_vld(edge_vld), .timer_val(timer_val),
        .pacc_val(pacc_val), .no_ovw(no_ovw), .queue_mode(queue_mode),
        .rd_cap(rd_cap), .rd_hold(rd_hold), .cap_data(cap_data),
        .hold_data(hold_data), .pacc_hold(pacc_hold), .cap_full(cap_full),
        .hold_full(hold_full), .cap_lost(cap_lost)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input vec_t v);
        check(req, {cap_data, hold_data, cap_full, hold_full, cap_lost, pacc_hold},
                   {v.ecap, v.ehold, v.ecf, v.ehf, v.elost, v.epacc});
    endtask

    task automatic drive(input vec_t v);
        edge_vld = v.ev; no_ovw = v.nov; rd_cap = v.rc; rd_hold = v.rh;
        queue_mode = v.qm; timer_val = v.tmr; pacc_val = v.pac;
    endtask

    task automatic idle();
        edge_vld = 0; rd_cap = 0; rd_hold = 0; queue_mode = 0; no_ovw = 0;
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {cap_data, hold_data, cap_full, hold_full, cap_lost, pacc_hold}, '0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            if (i == NV - 1)
                check("R7 pre-capture value visible", {48'd0, cap_data}, {48'd0, 16'h0088});
            @(negedge clk);
            idle();
            check_all($sformatf("vec%0d R2 R3 R4 R5 R6 R7 R8 R9 R10", i), VEC[i]);
        end

        // R10: lost flag persists through idle cycles
        repeat (5) @(negedge clk);
        check("R10 sticky", {63'd0, cap_lost}, 64'd1);

        // R6: capture read clears flag while holding stays empty
        rd_cap = 1; @(negedge clk); idle();
        check("R6 rd_cap", {62'd0, cap_full, hold_full}, 64'd0);

        // R2: load into empty stage with no_ovw set leaves holding alone
        edge_vld = 1; no_ovw = 1; timer_val = 16'hBEEF; @(negedge clk); idle();
        check("R2 novw load", {32'd0, cap_data, hold_data}, {32'd0, 16'hBEEF, 16'h0033});

        // R1: reset clears everything including sticky flag
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        check("R1 re-reset", {cap_data, hold_data, cap_full, hold_full, cap_lost, pacc_hold}, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule